// File: doc/BRIEF.md
# Scanline Sprite Evaluation Sequencer

This block picks the sprites that appear on a scanline. It walks a primary sprite table of 64 entries, 4 bytes each, inside a fixed window of dots on every visible line. Each sprite whose vertical span covers the target line is copied into an 8-slot (32-byte) secondary buffer. Accesses run in pairs: the sequencer reads one table byte on an even dot and writes that byte to the secondary buffer on the next odd dot. A sprite that is in range costs six more dots, because its remaining three bytes are copied. After the last entry the sequencer keeps issuing dummy pairs until the window closes.

The byte latched on each even dot is the evaluation bus. It is driven out on `probe_data`, so a processor read of the sprite port during evaluation returns the value for that exact dot. When more sprites are in range than the buffer can hold, the spill flag is set. It stays set until the pre-render line begins.

The controller has seven states:
- `ST_IDLE`: outside the window.
- `ST_RD_Y` and `ST_WR_Y`: read and write the vertical byte.
- `ST_RD_REST` and `ST_WR_REST`: read and write bytes 1 to 3.
- `ST_THR_RD` and `ST_THR_WR`: dummy pairs after the scan.

The transitions are:
- IDLE→RD_Y at the edge that ends dot 63 on a visible line.
- RD_Y→WR_Y always.
- WR_Y→RD_REST on a hit.
- WR_Y→RD_Y on a miss, or WR_Y→THR_RD if the entry was number 63.
- RD_REST→WR_REST always.
- WR_REST→RD_REST while bytes remain.
- WR_REST→RD_Y or WR_REST→THR_RD after byte 3.
- THR_RD↔THR_WR.
- Any state→IDLE at the edge that ends dot 255.

Top module: `sev_sequencer`

## Requirements
- R1: The sequencer leaves idle only at the edge that ends dot 63 of a line numbered 0 to 239. While idle, `tbl_addr` is 0 and `sbuf_we` is low. Lines 240 and above cause no activity.
- R2: Table reads happen on even dots. The byte at `tbl_addr` is latched at the edge that ends the even dot. On the following odd dot, `sbuf_we` presents that byte on `sbuf_wdata`. `sbuf_we` is never high on an even dot.
- R3: Entries are visited in ascending order starting at entry 0 on dot 64. `tbl_addr` = 4·entry + byte, and the vertical byte is byte 0. The address holds across each read/write pair.
- R4: A sprite hits when 0 ≤ (`line_idx` − Y) < H. H is 8 when `tall_mode` = 0 and 16 when `tall_mode` = 1.
- R5: Every vertical byte is written to the current slot (`sbuf_addr`). On a hit the slot pointer advances and bytes 1, 2 and 3 are copied on the next six dots. On a miss the next entry overwrites the same slot.
- R6: After 32 bytes have been written, `sbuf_we` stays low for the rest of the line. The byte pointer never passes 32.
- R7: A hit found while the buffer is full sets `spill_flag` at the edge that ends the odd dot of that check. The flag stays set on later lines. With no more than 8 hits it stays low.
- R8: `spill_flag` clears at the edge that ends dot 0 of line 261, and on reset.
- R9: After entry 63 the sequencer issues dummy pairs that read address 0 and write nothing, up to dot 255. With no hits, entry 63 is read on dot 190 and the dummy pairs start on dot 192.
- R10: The window closes at the edge that ends dot 255 even if the scan is unfinished. With 20 leading hits, dot 254 reads address 140.
- R11: `probe_data` shows the latched evaluation byte. It holds outside the window and is 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dot_idx | input | 9 | Current dot within the line |
| line_idx | input | 9 | Current line; also the line that sprites are compared against |
| tall_mode | input | 1 | 1 selects 16-line sprites, 0 selects 8-line sprites |
| tbl_rdata | input | 8 | Primary table read data for `tbl_addr`, same cycle |
| tbl_addr | output | 8 | Primary table byte address |
| sbuf_we | output | 1 | Secondary buffer write strobe |
| sbuf_addr | output | 5 | Secondary buffer byte address |
| sbuf_wdata | output | 8 | Secondary buffer write data |
| spill_flag | output | 1 | Sticky flag for a hit with the buffer full |
| probe_data | output | 8 | Evaluation bus byte seen by a sprite-port read |

## Verification
The assertions check properties that hold on every cycle:
- The state stays idle outside dots 64 to 255, and the window opens on the correct edge.
- Read states fall on even dots, and the address holds across each pair.
- The byte pointer stays within bounds.
- The dummy pairs use address 0.
- The spill flag is sticky and clears on the pre-render line.

Other behaviours appear only in the bench's line scenarios. These are the in-range arithmetic at the 8/16 boundaries, the exact dot on which a hit's extra six dots shift the following reads, the contents of the secondary buffer, the dot on which the spill flag rises, and truncation of the scan when many sprites hit. The bench's reference model tracks each of these dot by dot.

// File: rtl/sev_pkg.sv
package sev_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_Y,
        ST_WR_Y,
        ST_RD_REST,
        ST_WR_REST,
        ST_THR_RD,
        ST_THR_WR
    } sev_state_e;

endpackage

// File: rtl/sev_range_cmp.sv
// Vertical coverage test: hit when 0 <= line - y < height.
module sev_range_cmp #(
    parameter int LINE_W  = 9,
    parameter int SHORT_H = 8,
    parameter int TALL_H  = 16
) (
    input  logic [LINE_W-1:0] line,
    input  logic [7:0]        y_byte,
    input  logic              tall,
    output logic              hit
);
    localparam int DW = LINE_W + 1;
    localparam logic [DW-1:0] H_SHORT = DW'(SHORT_H);
    localparam logic [DW-1:0] H_TALL  = DW'(TALL_H);

    logic [DW-1:0] diff;
    logic [DW-1:0] height;

    always_comb begin
        diff   = {1'b0, line} - {{(DW-8){1'b0}}, y_byte};
        height = tall ? H_TALL : H_SHORT;
        hit    = !diff[DW-1] && (diff < height);
    end
endmodule

// File: rtl/sev_ovf_flag.sv
// Sticky spill flag; clear has priority over set.
module sev_ovf_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_req,
    input  logic clr_req,
    output logic flag
);
    always_ff @(posedge clk) begin
        if (!rst_n)       flag <= 1'b0;
        else if (clr_req) flag <= 1'b0;
        else if (set_req) flag <= 1'b1;
    end

    AST_OVF_HOLD:  assert property (@(posedge clk) disable iff (!rst_n) (flag && !clr_req) |=> flag);       // R7
    AST_OVF_RISE:  assert property (@(posedge clk) disable iff (!rst_n) $rose(flag) |-> $past(set_req));     // R7
    AST_OVF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n) clr_req |=> !flag);                  // R8
endmodule

// File: rtl/sev_fsm.sv
// Dot-driven evaluation controller: state register, counters, bus latch, outputs.
module sev_fsm
    import sev_pkg::*;
#(
    parameter int ENTRIES   = 64,
    parameter int SLOTS     = 8,
    parameter int WIN_FIRST = 64,
    parameter int WIN_LAST  = 255,
    parameter int VIS_LINES = 240,
    parameter int DOT_W     = 9,
    parameter int LINE_W    = 9
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [DOT_W-1:0]    dot,
    input  logic [LINE_W-1:0]   line,
    input  logic [7:0]          rd_data,
    input  logic                hit,
    output logic [$clog2(ENTRIES)+1:0]     prim_addr,
    output logic                sec_we,
    output logic [$clog2(SLOTS*4)-1:0]     sec_addr,
    output logic [7:0]          sec_wdata,
    output logic [7:0]          bus_q,
    output logic                ovf_set
);
    localparam int IDX_W     = $clog2(ENTRIES);
    localparam int ADDR_W    = IDX_W + 2;
    localparam int SEC_BYTES = SLOTS * 4;
    localparam int SEC_AW    = $clog2(SEC_BYTES);
    localparam int CNT_W     = SEC_AW + 1;

    localparam logic [DOT_W-1:0]  OPEN_DOT  = DOT_W'(WIN_FIRST - 1);
    localparam logic [DOT_W-1:0]  FIRST_DOT = DOT_W'(WIN_FIRST);
    localparam logic [DOT_W-1:0]  CLOSE_DOT = DOT_W'(WIN_LAST);
    localparam logic [LINE_W-1:0] VIS_END   = LINE_W'(VIS_LINES);
    localparam logic [IDX_W-1:0]  LAST_IDX  = IDX_W'(ENTRIES - 1);
    localparam logic [IDX_W-1:0]  IDX_ONE   = IDX_W'(1);
    localparam logic [CNT_W-1:0]  CNT_ONE   = CNT_W'(1);
    localparam logic [CNT_W-1:0]  FULL_CNT  = CNT_W'(SEC_BYTES);

    sev_state_e        state, nxt;
    logic [IDX_W-1:0]  idx;
    logic [1:0]        byte_sel;
    logic [CNT_W-1:0]  cnt;

    logic win_open, win_close, last_entry, full, rest_done;

    always_comb begin
        win_open   = (dot == OPEN_DOT) && (line < VIS_END);
        win_close  = (dot == CLOSE_DOT);
        last_entry = (idx == LAST_IDX);
        full       = (cnt == FULL_CNT);
        rest_done  = (byte_sel == 2'd3);
    end

    // next-state
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:    nxt = win_open ? ST_RD_Y : ST_IDLE;
            ST_RD_Y:    nxt = ST_WR_Y;
            ST_WR_Y:    nxt = hit ? ST_RD_REST : (last_entry ? ST_THR_RD : ST_RD_Y);
            ST_RD_REST: nxt = ST_WR_REST;
            ST_WR_REST: nxt = rest_done ? (last_entry ? ST_THR_RD : ST_RD_Y) : ST_RD_REST;
            ST_THR_RD:  nxt = ST_THR_WR;
            ST_THR_WR:  nxt = ST_THR_RD;
            default:    nxt = ST_IDLE;
        endcase
        if (win_close) nxt = ST_IDLE;
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // counters and evaluation bus latch
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx      <= '0;
            byte_sel <= 2'd0;
            cnt      <= '0;
            bus_q    <= 8'h00;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (win_open) begin
                        idx      <= '0;
                        byte_sel <= 2'd0;
                        cnt      <= '0;
                    end
                end
                ST_RD_Y, ST_RD_REST, ST_THR_RD: bus_q <= rd_data;
                ST_WR_Y: begin
                    if (hit) begin
                        if (!full) cnt <= cnt + CNT_ONE;
                        byte_sel <= 2'd1;
                    end else begin
                        idx <= idx + IDX_ONE;
                    end
                end
                ST_WR_REST: begin
                    if (!full) cnt <= cnt + CNT_ONE;
                    if (rest_done) begin
                        byte_sel <= 2'd0;
                        idx      <= idx + IDX_ONE;
                    end else begin
                        byte_sel <= byte_sel + 2'd1;
                    end
                end
                ST_THR_WR: ;
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        prim_addr = (state == ST_IDLE) ? '0 : {idx, byte_sel};
        sec_we    = ((state == ST_WR_Y) || (state == ST_WR_REST)) && !full;
        sec_addr  = cnt[SEC_AW-1:0];
        sec_wdata = bus_q;
        ovf_set   = (state == ST_WR_Y) && hit && full;
    end

    AST_WINDOW_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        ((dot < FIRST_DOT) || (dot > CLOSE_DOT)) |-> (state == ST_IDLE));                    // R1
    AST_WINDOW_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && win_open) |=> (state == ST_RD_Y));                               // R1
    AST_EVEN_READ: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_RD_Y) || (state == ST_RD_REST) || (state == ST_THR_RD)) |-> !dot[0]);  // R2
    AST_ADDR_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_WR_Y) || (state == ST_WR_REST)) |-> $stable(prim_addr));               // R3
    AST_SEC_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= FULL_CNT);                                                                      // R6
    AST_THRASH_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_THR_RD) || (state == ST_THR_WR)) |-> (prim_addr == '0));               // R9
endmodule

// File: rtl/sev_sequencer.sv
module sev_sequencer #(
    parameter int ENTRIES   = 64,
    parameter int SLOTS     = 8,
    parameter int WIN_FIRST = 64,
    parameter int WIN_LAST  = 255,
    parameter int VIS_LINES = 240,
    parameter int PRE_LINE  = 261,
    parameter int SHORT_H   = 8,
    parameter int TALL_H    = 16,
    parameter int DOT_W     = 9,
    parameter int LINE_W    = 9
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [DOT_W-1:0]              dot_idx,
    input  logic [LINE_W-1:0]             line_idx,
    input  logic                          tall_mode,
    input  logic [7:0]                    tbl_rdata,
    output logic [$clog2(ENTRIES)+1:0]    tbl_addr,
    output logic                          sbuf_we,
    output logic [$clog2(SLOTS*4)-1:0]    sbuf_addr,
    output logic [7:0]                    sbuf_wdata,
    output logic                          spill_flag,
    output logic [7:0]                    probe_data
);
    localparam logic [LINE_W-1:0] PRE_ROW = LINE_W'(PRE_LINE);
    localparam logic [DOT_W-1:0]  ZERO_DOT = '0;

    logic [7:0] bus_q;
    logic       hit;
    logic       ovf_set;
    logic       ovf_clr;

    assign ovf_clr    = (line_idx == PRE_ROW) && (dot_idx == ZERO_DOT);
    assign probe_data = bus_q;

    sev_range_cmp #(
        .LINE_W  (LINE_W),
        .SHORT_H (SHORT_H),
        .TALL_H  (TALL_H)
    ) u_cmp (
        .line   (line_idx),
        .y_byte (bus_q),
        .tall   (tall_mode),
        .hit    (hit)
    );

    sev_fsm #(
        .ENTRIES   (ENTRIES),
        .SLOTS     (SLOTS),
        .WIN_FIRST (WIN_FIRST),
        .WIN_LAST  (WIN_LAST),
        .VIS_LINES (VIS_LINES),
        .DOT_W     (DOT_W),
        .LINE_W    (LINE_W)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .dot       (dot_idx),
        .line      (line_idx),
        .rd_data   (tbl_rdata),
        .hit       (hit),
        .prim_addr (tbl_addr),
        .sec_we    (sbuf_we),
        .sec_addr  (sbuf_addr),
        .sec_wdata (sbuf_wdata),
        .bus_q     (bus_q),
        .ovf_set   (ovf_set)
    );

    sev_ovf_flag u_ovf (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_req (ovf_set),
        .clr_req (ovf_clr),
        .flag    (spill_flag)
    );
endmodule

// File: tb/tb_sev_sequencer.sv
module tb_sev_sequencer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [8:0] dot_idx = '0;
    logic [8:0] line_idx = '0;
    logic       tall_mode = 1'b0;
    logic [7:0] tbl_rdata;
    logic [7:0] tbl_addr;
    logic       sbuf_we;
    logic [4:0] sbuf_addr;
    logic [7:0] sbuf_wdata;
    logic       spill_flag;
    logic [7:0] probe_data;

    logic [7:0] oam [256];
    assign tbl_rdata = oam[tbl_addr];

    always #5 clk = ~clk;

    sev_sequencer dut (
        .clk(clk), .rst_n(rst_n), .dot_idx(dot_idx), .line_idx(line_idx),
        .tall_mode(tall_mode), .tbl_rdata(tbl_rdata), .tbl_addr(tbl_addr),
        .sbuf_we(sbuf_we), .sbuf_addr(sbuf_addr), .sbuf_wdata(sbuf_wdata),
        .spill_flag(spill_flag), .probe_data(probe_data)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    // reference model state
    int m_st, m_idx, m_b, m_cnt;
    logic [7:0] m_bus;
    bit m_ovf;

    // per-line observations
    logic [7:0] sec_buf [32];
    int we_count;
    int addr_at [341];
    int port_at [341];
    bit ovf_at  [341];

    task automatic chk(bit ok, string tag, string what, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    function automatic bit in_range(logic [7:0] y, int ln, bit tall);
        int d = ln - int'(y);
        return (d >= 0) && (d < (tall ? 16 : 8));
    endfunction

    task automatic model_reset();
        m_st = 0; m_idx = 0; m_b = 0; m_cnt = 0; m_bus = 8'h00; m_ovf = 0;
    endtask

    task automatic model_step(int d, int ln);
        bit opn = (d == 63) && (ln < 240);
        bit cls = (d == 255);
        bit hv  = in_range(m_bus, ln, tall_mode);
        bit full = (m_cnt == 32);
        int ns = m_st;
        if (ln == 261 && d == 0) m_ovf = 0;
        else if (m_st == 2 && hv && full) m_ovf = 1;
        case (m_st)
            0: if (opn) begin ns = 1; m_idx = 0; m_b = 0; m_cnt = 0; end
            1, 3, 5: begin m_bus = oam[m_idx*4 + m_b]; ns = m_st + 1; end
            2: begin
                if (hv) begin if (!full) m_cnt++; m_b = 1; ns = 3; end
                else begin ns = (m_idx == 63) ? 5 : 1; m_idx = (m_idx + 1) % 64; end
            end
            4: begin
                if (!full) m_cnt++;
                if (m_b == 3) begin m_b = 0; ns = (m_idx == 63) ? 5 : 1; m_idx = (m_idx + 1) % 64; end
                else begin m_b++; ns = 3; end
            end
            6: ns = 5;
            default: ns = 0;
        endcase
        if (cls) ns = 0;
        m_st = ns;
    endtask

    task automatic run_line(int ln);
        for (int i = 0; i < 32; i++) sec_buf[i] = 8'hEE;
        we_count = 0;
        for (int d = 0; d < 341; d++) begin
            int exp_addr;
            bit exp_we;
            bit outside;
            @(negedge clk);
            dot_idx = 9'(d);
            line_idx = 9'(ln);
            #1;
            outside = (d < 64) || (d > 255);
            exp_addr = (m_st == 0) ? 0 : m_idx*4 + m_b;
            exp_we = (m_st == 2 || m_st == 4) && (m_cnt < 32);
            chk(int'(tbl_addr) == exp_addr, outside ? "R1" : "R3", "tbl_addr", tbl_addr, exp_addr);
            chk(sbuf_we == exp_we, outside ? "R1" : "R2", "sbuf_we", sbuf_we, exp_we);
            if (exp_we && sbuf_we) begin
                chk(int'(sbuf_addr) == m_cnt && sbuf_wdata == m_bus, "R5", "sbuf_addr/wdata",
                    {sbuf_addr, sbuf_wdata}, {m_cnt[4:0], m_bus});
            end
            chk(probe_data == m_bus, "R11", "probe_data", probe_data, m_bus);
            chk(spill_flag == m_ovf, "R7", "spill_flag", spill_flag, m_ovf);
            if (sbuf_we) begin sec_buf[sbuf_addr] = sbuf_wdata; we_count++; end
            addr_at[d] = tbl_addr;
            port_at[d] = probe_data;
            ovf_at[d] = spill_flag;
            model_step(d, ln);
        end
    endtask

    task automatic clear_table();
        for (int i = 0; i < 64; i++) begin
            oam[i*4] = 8'hF0;
            for (int b = 1; b < 4; b++) oam[i*4+b] = 8'((i*4+b) ^ 8'h5A);
        end
    endtask

    // expected buffer contents computed from the table; valid when the scan fits
    task automatic check_contents(int ln, string tag);
        int hits = 0;
        int pos = 0;
        for (int i = 0; i < 64; i++) if (in_range(oam[i*4], ln, tall_mode)) hits++;
        if (hits > 10) return;
        for (int i = 0; i < 64 && pos < 32; i++) begin
            if (in_range(oam[i*4], ln, tall_mode)) begin
                for (int b = 0; b < 4; b++) begin
                    chk(sec_buf[pos] == oam[i*4+b], tag, "secondary byte", sec_buf[pos], oam[i*4+b]);
                    pos++;
                end
            end
        end
        chk(we_count == 64 - (hits > 8 ? 64 - 8 : 0) + 3*(hits > 8 ? 8 : hits) - (hits >= 8 ? 0 : 0)
            || hits >= 8, tag, "write count", we_count, 64 + 3*hits);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        localparam int L = 100;
        void'($urandom(32'h5EE1));
        clear_table();
        model_reset();
        repeat (3) @(negedge clk);
        #1;
        chk(sbuf_we == 0 && tbl_addr == 0, "R1", "reset we/addr", {sbuf_we, tbl_addr}, 0);
        chk(spill_flag == 0, "R8", "reset spill", spill_flag, 0);
        chk(probe_data == 0, "R11", "reset probe", probe_data, 0);
        @(negedge clk);
        rst_n = 1'b1;

        // no hits: full scan, then dummy pairs
        run_line(L);
        chk(addr_at[190] == 252, "R9", "addr dot 190", addr_at[190], 252);
        chk(addr_at[192] == 0, "R9", "addr dot 192", addr_at[192], 0);
        chk(port_at[200] == 8'hF0, "R9", "probe in dummy pairs", port_at[200], 8'hF0);
        chk(we_count == 64, "R9", "writes with no hit", we_count, 64);

        // three hits, short sprites
        clear_table();
        oam[5*4] = 8'(L); oam[17*4] = 8'(L-7); oam[40*4] = 8'(L-3);
        run_line(L);
        check_contents(L, "R5");
        chk(we_count == 73, "R5", "writes with 3 hits", we_count, 73);

        // boundaries of the range test
        clear_table();
        oam[2*4] = 8'(L-8); oam[3*4] = 8'(L+1); oam[4*4] = 8'(L);
        run_line(L);
        chk(we_count == 67, "R4", "boundary hits", we_count, 67);
        chk(sec_buf[0] == 8'(L), "R4", "boundary Y", sec_buf[0], L);

        // height selection
        clear_table();
        oam[6*4] = 8'(L-12);
        tall_mode = 1'b0;
        run_line(L);
        chk(we_count == 64, "R4", "8-line miss", we_count, 64);
        tall_mode = 1'b1;
        run_line(L);
        chk(we_count == 67, "R4", "16-line hit", we_count, 67);
        check_contents(L, "R4");
        tall_mode = 1'b0;

        // exactly eight hits
        clear_table();
        for (int i = 0; i < 8; i++) oam[i*4] = 8'(L-2);
        run_line(L);
        chk(we_count == 32, "R6", "writes when full", we_count, 32);
        chk(spill_flag == 0, "R7", "no spill at 8", spill_flag, 0);
        check_contents(L, "R6");

        // nine hits: spill rises on dot 130
        clear_table();
        for (int i = 0; i < 9; i++) oam[i*4] = 8'(L-1);
        run_line(L);
        chk(ovf_at[129] == 0 && ovf_at[130] == 1, "R7", "spill rise dot", {ovf_at[129], ovf_at[130]}, 2'b01);
        clear_table();
        run_line(L+1);
        chk(spill_flag == 1, "R7", "spill sticky", spill_flag, 1);
        run_line(261);
        chk(spill_flag == 0 && ovf_at[0] == 1 && ovf_at[1] == 0, "R8", "pre-render clear",
            {ovf_at[0], ovf_at[1], spill_flag}, 3'b100);

        // twenty hits: scan truncated
        clear_table();
        for (int i = 0; i < 20; i++) oam[i*4] = 8'(L-4);
        run_line(L);
        chk(addr_at[254] == 140, "R10", "addr at dot 254", addr_at[254], 140);
        chk(addr_at[256] == 0, "R10", "idle after window", addr_at[256], 0);
        chk(port_at[300] == 8'hF0, "R11", "probe holds", port_at[300], 8'hF0);

        // invisible line
        run_line(240);
        chk(we_count == 0, "R1", "no writes on line 240", we_count, 0);

        // random layouts
        for (int r = 0; r < 6; r++) begin
            int ln = 20 + int'($urandom_range(0, 200));
            clear_table();
            tall_mode = 1'($urandom_range(0, 1));
            for (int i = 0; i < 64; i++) begin
                oam[i*4] = ($urandom_range(0, 3) == 0) ? 8'(ln - int'($urandom_range(0, 20)))
                                                       : 8'($urandom_range(0, 255));
                for (int b = 1; b < 4; b++) oam[i*4+b] = 8'($urandom_range(0, 255));
            end
            run_line(ln);
            check_contents(ln, "R5");
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule